// File: doc/BRIEF.md
# PLL Phase Error and Lock Detector

This block sits beside a phase-locked loop and decides, once per reference cycle, whether the loop is still locked. It watches two single-cycle pulse streams in the system clock domain: the reference pulse and the pulse from the feedback divider. When one of them rises, a counter starts. It stops when the other one rises. The count is the phase error in system clock cycles. If that count is larger than a tolerance window chosen by a three-bit select, the pair counts as a phase error.

A missing pulse also counts as an error. This covers a second reference edge with no feedback edge in between, and either pulse waiting for its partner for a whole reference period (a fixed cycle timeout). Any error sets a sticky unlock flag. The flag stays set until the host reads the status. A read is a one-cycle strobe. One cycle later the block returns an acknowledge together with the flag value as it stood before the read, and the flag is cleared.

The window is a whole multiple of a base step in clock cycles. Select 0 turns the window comparison off, so only missing-pulse errors are reported. A parameter picks the rule for the other select codes: odd multiples of the step (default) or plain multiples.

Top module: `pld_lock_detect`

## Requirements
- R1: After reset, `unlock_o`, `ack_o` and `rd_unlock_o` are all 0.
- R2: A reference/feedback pair whose edges are at most the selected window apart never sets the unlock flag, whichever edge comes first.
- R3: When the feedback edge lags the reference edge by more than the selected window, the unlock flag is set.
- R4: When the feedback edge leads the reference edge by more than the selected window, the unlock flag is set.
- R5: With the default window rule, select code k (1 to 7) gives a window of (2k-1)*STEP_CYC system clock cycles. An offset of exactly that many cycles is within tolerance, and one cycle more is an error.
- R6: Select code 0 turns the window comparison off, so a matched pair with any offset shorter than the timeout leaves the flag clear.
- R7: A reference edge that gets no feedback edge is an error. This applies when a second reference edge arrives first, or when TIMEOUT_CYC cycles pass.
- R8: A feedback edge that gets no reference edge within TIMEOUT_CYC cycles is an error.
- R9: A one-cycle `rd_i` strobe gives `ack_o`=1 for one cycle on the next cycle, with `rd_unlock_o` equal to the flag before the read. The flag is clear afterwards unless a new error arrives in the same cycle.
- R10: Once set, the unlock flag stays set through any number of locked pairs until a read clears it.
- R11: Reference and feedback edges in the same cycle are a zero phase error and never set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_pulse_i | input | 1 | Reference pulse |
| fb_pulse_i | input | 1 | Divided feedback pulse |
| win_sel_i | input | 3 | Tolerance window select, 0 turns the window check off |
| rd_i | input | 1 | Status read strobe (clears the flag) |
| ack_o | output | 1 | Read acknowledge, one cycle after `rd_i` |
| rd_unlock_o | output | 1 | Flag value returned with `ack_o` |
| unlock_o | output | 1 | Live sticky unlock flag |

## Verification
The bench goes after the window edges. It uses offsets of exactly the window and one cycle more at the smallest and largest codes. A design with an off-by-one counter or a `>=` compare would flag the in-tolerance case, or pass the failing one. It checks both lead directions and coincident edges. A meter that only counts from the reference edge would miss feedback-leading errors. A detector that counts a same-cycle pair as one cycle would trip on perfect lock.

The bench also removes a pulse in three ways: a doubled reference, a lone reference, and a lone feedback edge. A design without the timeout or the double-edge rule would report lock while the loop has lost a signal. Finally it checks that the flag survives many locked cycles and clears only on a read. A non-sticky flag would read back 0, and a flag that ignores the read would stay set after it.

// File: rtl/pld_pkg.sv
package pld_pkg;

   typedef enum logic [1:0] {
      PH_IDLE     = 2'd0,
      PH_REF_LEAD = 2'd1,
      PH_FB_LEAD  = 2'd2
   } ph_state_e;

   // Window rule variants
   localparam int WIN_ODD    = 0;
   localparam int WIN_LINEAR = 1;

   // Multiple of the base step for a select code; 0 means the check is off.
   function automatic int unsigned win_mult(input int unsigned code, input int mode);
      if (code == 0)
         return 0;
      else if (mode == WIN_LINEAR)
         return code;
      else
         return 2 * code - 1;
   endfunction

endpackage

// File: rtl/pld_edge_sync.sv
module pld_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic rise_o
);

   logic sync_q;
   logic prev_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign sync_q = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               chain_q <= '0;
            else if (STAGES == 1)
               chain_q <= d_i;
            else
               chain_q <= {chain_q[STAGES-2:0], d_i};
         end
         assign sync_q = chain_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         prev_q <= 1'b0;
      else
         prev_q <= sync_q;
   end

   assign rise_o = sync_q & ~prev_q;

endmodule

// File: rtl/pld_window_sel.sv
module pld_window_sel
   import pld_pkg::*;
#(
   parameter int SEL_W    = 3,
   parameter int STEP_CYC = 110,
   parameter int CNT_W    = 12,
   parameter int MODE     = WIN_ODD
) (
   input  logic [SEL_W-1:0] sel_i,
   output logic [CNT_W-1:0] thr_o,
   output logic             chk_en_o
);

   localparam int NUM_CODES = 1 << SEL_W;

   logic [CNT_W-1:0] table_w [NUM_CODES];

   generate
      for (genvar g = 0; g < NUM_CODES; g++) begin : g_tbl
         localparam int unsigned LIMIT = win_mult(g, MODE) * STEP_CYC;
         if (LIMIT >= (1 << CNT_W)) begin : g_bad
            $error("window limit does not fit the counter width");
         end
         assign table_w[g] = CNT_W'(LIMIT);
      end
   endgenerate

   assign thr_o    = table_w[sel_i];
   assign chk_en_o = (sel_i != '0);

endmodule

// File: rtl/pld_phase_meter.sv
module pld_phase_meter
   import pld_pkg::*;
#(
   parameter int CNT_W       = 12,
   parameter int TIMEOUT_CYC = 4000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_rise_i,
   input  logic             fb_rise_i,
   input  logic [CNT_W-1:0] thr_i,
   input  logic             chk_en_i,
   output logic             err_o
);

   localparam logic [CNT_W-1:0] TMO = CNT_W'(TIMEOUT_CYC);

   ph_state_e        state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             err_d;
   logic             over_win;

   assign over_win = chk_en_i && (cnt_q > thr_i);

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      err_d   = 1'b0;
      unique case (state_q)
         PH_IDLE: begin
            if (ref_rise_i && fb_rise_i) begin
               state_d = PH_IDLE;
            end else if (ref_rise_i) begin
               state_d = PH_REF_LEAD;
               cnt_d   = CNT_W'(1);
            end else if (fb_rise_i) begin
               state_d = PH_FB_LEAD;
               cnt_d   = CNT_W'(1);
            end
         end
         PH_REF_LEAD: begin
            if (fb_rise_i) begin
               err_d = over_win;
               if (ref_rise_i) begin
                  state_d = PH_REF_LEAD;
                  cnt_d   = CNT_W'(1);
               end else begin
                  state_d = PH_IDLE;
               end
            end else if (ref_rise_i) begin
               err_d = 1'b1;
               cnt_d = CNT_W'(1);
            end else if (cnt_q >= TMO) begin
               err_d   = 1'b1;
               state_d = PH_IDLE;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         PH_FB_LEAD: begin
            if (ref_rise_i) begin
               err_d = over_win;
               if (fb_rise_i) begin
                  state_d = PH_FB_LEAD;
                  cnt_d   = CNT_W'(1);
               end else begin
                  state_d = PH_IDLE;
               end
            end else if (fb_rise_i) begin
               err_d = 1'b1;
               cnt_d = CNT_W'(1);
            end else if (cnt_q >= TMO) begin
               err_d   = 1'b1;
               state_d = PH_IDLE;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         default: begin
            state_d = PH_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PH_IDLE;
         cnt_q   <= '0;
         err_o   <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         err_o   <= err_d;
      end
   end

endmodule

// File: rtl/pld_sticky_status.sv
module pld_sticky_status (
   input  logic clk,
   input  logic rst_n,
   input  logic err_i,
   input  logic rd_i,
   output logic ack_o,
   output logic rd_unlock_o,
   output logic unlock_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unlock_o    <= 1'b0;
         ack_o       <= 1'b0;
         rd_unlock_o <= 1'b0;
      end else begin
         ack_o <= rd_i;
         if (rd_i)
            rd_unlock_o <= unlock_o;
         if (err_i)
            unlock_o <= 1'b1;
         else if (rd_i)
            unlock_o <= 1'b0;
      end
   end

endmodule

// File: rtl/pld_lock_detect.sv
module pld_lock_detect
   import pld_pkg::*;
#(
   parameter int SEL_W       = 3,
   parameter int STEP_CYC    = 110,
   parameter int TIMEOUT_CYC = 4000,
   parameter int SYNC_STAGES = 2,
   parameter int WIN_MODE    = WIN_ODD
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_pulse_i,
   input  logic             fb_pulse_i,
   input  logic [SEL_W-1:0] win_sel_i,
   input  logic             rd_i,
   output logic             ack_o,
   output logic             rd_unlock_o,
   output logic             unlock_o
);

   localparam int CNT_W   = $clog2(TIMEOUT_CYC + 1);
   localparam int MAX_WIN = win_mult((1 << SEL_W) - 1, WIN_MODE) * STEP_CYC;

   generate
      if (STEP_CYC < 1) begin : g_chk_step
         $error("STEP_CYC must be at least 1");
      end
      if (MAX_WIN >= TIMEOUT_CYC) begin : g_chk_tmo
         $error("largest window must be shorter than the timeout");
      end
      if (WIN_MODE != WIN_ODD && WIN_MODE != WIN_LINEAR) begin : g_chk_mode
         $error("unknown window rule");
      end
   endgenerate

   logic             ref_rise;
   logic             fb_rise;
   logic [CNT_W-1:0] win_thr;
   logic             win_en;
   logic             meter_err;

   pld_edge_sync #(.STAGES(SYNC_STAGES)) i_ref_sync (
      .clk(clk), .rst_n(rst_n), .d_i(ref_pulse_i), .rise_o(ref_rise)
   );

   pld_edge_sync #(.STAGES(SYNC_STAGES)) i_fb_sync (
      .clk(clk), .rst_n(rst_n), .d_i(fb_pulse_i), .rise_o(fb_rise)
   );

   pld_window_sel #(
      .SEL_W(SEL_W), .STEP_CYC(STEP_CYC), .CNT_W(CNT_W), .MODE(WIN_MODE)
   ) i_win (
      .sel_i(win_sel_i), .thr_o(win_thr), .chk_en_o(win_en)
   );

   pld_phase_meter #(.CNT_W(CNT_W), .TIMEOUT_CYC(TIMEOUT_CYC)) i_meter (
      .clk(clk), .rst_n(rst_n),
      .ref_rise_i(ref_rise), .fb_rise_i(fb_rise),
      .thr_i(win_thr), .chk_en_i(win_en),
      .err_o(meter_err)
   );

   pld_sticky_status i_status (
      .clk(clk), .rst_n(rst_n),
      .err_i(meter_err), .rd_i(rd_i),
      .ack_o(ack_o), .rd_unlock_o(rd_unlock_o), .unlock_o(unlock_o)
   );

endmodule

// File: rtl/pld_lock_detect_chk.sv
module pld_lock_detect_chk (
   input logic clk,
   input logic rst_n,
   input logic rd_i,
   input logic ack_o,
   input logic rd_unlock_o,
   input logic unlock_o,
   input logic err
);

   // R3 R4 R7 R8: a detected error always raises the flag
   a_r3_err_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> unlock_o);

   // R10: the flag holds until a read
   a_r10_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (unlock_o && !rd_i) |=> unlock_o);

   // R2: no flag without an error
   a_r2_no_spontaneous_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!unlock_o && !err) |=> !unlock_o);

   // R9: a read with no new error clears the flag
   a_r9_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_i && !err) |=> !unlock_o);

   a_r9_ack_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i |=> ack_o);

   a_r9_no_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_i |=> !ack_o);

   a_r9_read_value: assert property (@(posedge clk) disable iff (!rst_n)
      rd_i |=> (rd_unlock_o == $past(unlock_o)));

endmodule

bind pld_lock_detect pld_lock_detect_chk i_chk (
   .clk(clk), .rst_n(rst_n), .rd_i(rd_i), .ack_o(ack_o),
   .rd_unlock_o(rd_unlock_o), .unlock_o(unlock_o), .err(meter_err)
);

// File: tb/test_pld_lock_detect.sv
`timescale 1ns/1ps
module test_pld_lock_detect;

   localparam int STEP = 110;
   localparam int TMO  = 4000;
   localparam int PER  = 3000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_p = 1'b0;
   logic       fb_p = 1'b0;
   logic [2:0] sel = 3'd1;
   logic       rd = 1'b0;
   logic       ack, rd_unl, unl;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pld_lock_detect #(.STEP_CYC(STEP), .TIMEOUT_CYC(TMO)) i_pld_lock_detect (
      .clk(clk), .rst_n(rst_n), .ref_pulse_i(ref_p), .fb_pulse_i(fb_p),
      .win_sel_i(sel), .rd_i(rd), .ack_o(ack), .rd_unlock_o(rd_unl),
      .unlock_o(unl)
   );

   task automatic chk(input bit cond, input string req, input int act, input int exp);
      n_cmp++;
      if (!cond) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // One read strobe; returns ack and data seen the following cycle
   task automatic do_read(output logic a, output logic d);
      @(negedge clk);
      rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
      a = ack;
      d = rd_unl;
   endtask

   task automatic read_expect(input string req, input logic exp);
      logic a, d;
      do_read(a, d);
      chk(a == 1'b1, req, a, 1);
      chk(d == exp, req, d, exp);
      @(negedge clk);
      chk(ack == 1'b0, req, ack, 0);
   endtask

   task automatic clear_flag();
      logic a, d;
      do_read(a, d);
      idle(2);
   endtask

   // nper periods; pulses at offsets rpos/fpos in each period (-1 = none)
   task automatic run_pairs(input int rpos, input int fpos, input int nper);
      for (int p = 0; p < nper; p++) begin
         for (int c = 0; c < PER; c++) begin
            @(negedge clk);
            ref_p = (c == rpos);
            fb_p  = (c == fpos);
         end
      end
      @(negedge clk);
      ref_p = 1'b0;
      fb_p  = 1'b0;
      idle(20);
   endtask

   task automatic t_reset();
      chk(unl == 1'b0, "R1 unlock", unl, 0);
      chk(ack == 1'b0, "R1 ack", ack, 0);
      chk(rd_unl == 1'b0, "R1 rd_unlock", rd_unl, 0);
   endtask

   task automatic t_locked();
      sel = 3'd3;                 // window 5*STEP = 550
      clear_flag();
      run_pairs(10, 310, 2);      // feedback lags by 300
      run_pairs(310, 10, 2);      // feedback leads by 300
      chk(unl == 1'b0, "R2 live flag", unl, 0);
      read_expect("R2 in-window pairs", 1'b0);
      run_pairs(100, 100, 3);     // coincident edges
      read_expect("R11 coincident edges", 1'b0);
   endtask

   task automatic t_low_boundary();
      sel = 3'd1;                 // window 110
      clear_flag();
      run_pairs(10, 10 + STEP, 2);
      read_expect("R5 offset equal to window code 1", 1'b0);
      run_pairs(10, 10 + STEP + 1, 1);
      chk(unl == 1'b1, "R3 lag live flag", unl, 1);
      read_expect("R3 lag one past window", 1'b1);
   endtask

   task automatic t_lead();
      sel = 3'd1;
      clear_flag();
      run_pairs(10 + 200, 10, 1);
      read_expect("R4 feedback leads past window", 1'b1);
   endtask

   task automatic t_high_boundary();
      sel = 3'd7;                 // window 13*STEP = 1430
      clear_flag();
      run_pairs(10, 10 + 13 * STEP, 2);
      read_expect("R5 offset equal to window code 7", 1'b0);
      run_pairs(10 + 13 * STEP + 1, 10, 1);
      read_expect("R5 one past window code 7", 1'b1);
   endtask

   task automatic t_disabled();
      sel = 3'd0;
      clear_flag();
      run_pairs(10, 1510, 2);
      read_expect("R6 window off ignores offset", 1'b0);
   endtask

   task automatic t_double_ref();
      sel = 3'd3;
      clear_flag();
      run_pairs(10, -1, 1);       // first ref
      run_pairs(10, -1, 1);       // second ref, before timeout
      read_expect("R7 second reference without feedback", 1'b1);
      idle(TMO + 100);            // let the pending timeout pass
      clear_flag();
   endtask

   task automatic t_lone_ref();
      sel = 3'd3;
      clear_flag();
      run_pairs(10, -1, 1);
      idle(TMO);
      read_expect("R7 reference timeout", 1'b1);
      read_expect("R9 flag cleared by read", 1'b0);
   endtask

   task automatic t_lone_fb();
      sel = 3'd3;
      clear_flag();
      run_pairs(-1, 10, 1);
      chk(unl == 1'b0, "R8 no flag before timeout", unl, 0);
      idle(TMO);
      read_expect("R8 feedback timeout", 1'b1);
   endtask

   task automatic t_sticky();
      sel = 3'd1;
      clear_flag();
      run_pairs(10, 400, 1);      // error
      run_pairs(10, 20, 4);       // locked again
      chk(unl == 1'b1, "R10 flag held", unl, 1);
      read_expect("R10 sticky after lock regained", 1'b1);
      chk(unl == 1'b0, "R9 live flag after read", unl, 0);
      read_expect("R9 second read", 1'b0);
   endtask

   initial begin
      idle(5);
      t_reset();
      rst_n = 1'b1;
      idle(5);
      t_reset();
      t_locked();
      t_low_boundary();
      t_lead();
      t_high_boundary();
      t_disabled();
      t_double_ref();
      t_lone_ref();
      t_lone_fb();
      t_sticky();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (195000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule